// File: doc/BRIEF.md
# Watchdog Reset Timer

This block is a watchdog that software drives through one limit register on a simple single-cycle register bus. Storing a nonzero limit arms the watchdog: an internal up-counter restarts from zero and advances by one on every clock. Storing zero disarms it and freezes the counter. If software does not intervene before the counter equals the limit, the block drives two active-low reset outputs, one for the peripherals and one for the whole system, for a fixed number of clocks. It then returns to the idle state with the limit cleared.

Software keeps the system alive by rewriting a nonzero limit at regular intervals. Each rewrite restarts the count, and no zero write is needed first. The limit, the live counter and a status word can all be read back. The timer runs on the register-bus clock. The asynchronous reset input is released to the logic through a two-stage synchronizer.

Top module: `wdog_timer`

## Requirements
- R1: After reset the watchdog is disarmed (`armed` = 0), both reset outputs are high, and the limit and counter both read 0.
- R2: A write of a nonzero value to the limit address (offset 0x0) stores that value, clears the counter to 0 and sets `armed`. While armed and below the limit, the counter increases by exactly one per clock.
- R3: When the counter value equals the limit while armed and no limit write occurs in that cycle, both reset outputs go low at the next clock edge and `armed` drops. For a limit L written at edge E, the outputs are first low after edge E+L+1.
- R4: The two reset outputs are always equal. Once low, they stay low for exactly PULSE_LEN clocks (default 16), then return high. The limit then reads 0.
- R5: A write of zero to the limit address clears `armed` and the limit, and freezes the counter at its current value. No reset pulse follows.
- R6: A nonzero write while armed restarts the counter from 0 against the new limit.
- R7: A limit write in the same cycle as the terminal count takes priority. A zero write disarms, a nonzero write re-arms, and no reset pulse is produced.
- R8: Writes to the limit address are ignored while the reset outputs are low.
- R9: With `rd_en` high, address 0x0 returns the limit, 0x4 returns the counter, and 0x8 returns the status (bit 0 = armed, bit 1 = reset pulse active). Any other address, or `rd_en` low, returns 0. Writes to addresses other than 0x0 have no effect.
- R10: Driving `rst_n` low releases the reset outputs and disarms the block at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read enable for the combinational read mux |
| addr | input | ADDR_W (4) | Byte address of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data |
| armed | output | 1 | High while the watchdog is counting |
| periph_rst_n | output | 1 | Active-low peripheral reset pulse |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
The hardest situation to reach is a limit write that falls exactly on the terminal-count cycle. Only a write placed on that one clock shows whether the write beats the expiry. The stimulus counts clocks from the arming write and places a zero or nonzero write on cycle L, next to cases one cycle earlier that must also stay silent. A write landing inside an active reset pulse is reached the same way, by waiting a known number of clocks after arming before writing.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Number of active-low reset outputs driven from the same pulse.
  localparam int RST_OUTS = 2;

  // Index of each reset output in the output vector.
  typedef enum int {
    OUT_PERIPH = 0,
    OUT_SYSTEM = 1
  } wdog_out_e;

  // Status word, packed into the low bits of the read data.
  typedef struct packed {
    logic pulse;
    logic armed;
  } wdog_status_t;

  // Widen the status word to the read-data width.
  function automatic logic [31:0] status_word(input wdog_status_t st);
    logic [31:0] w;
    w      = '0;
    w[1:0] = st;
    return w;
  endfunction

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  // Assertion is asynchronous; release passes through two flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int LIMIT_ADDR  = 0,
  parameter int COUNT_ADDR  = 4,
  parameter int STATUS_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  input  logic              pulse_act,
  input  logic              armed,
  input  logic [DATA_W-1:0] count,
  output logic              wr_hit,
  output logic              wr_arm,
  output logic              wr_stop,
  output logic [DATA_W-1:0] limit_q,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] A_LIMIT  = ADDR_W'(LIMIT_ADDR);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(COUNT_ADDR);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_ADDR);

  logic              limit_en;
  logic [DATA_W-1:0] limit_d;
  wdog_status_t      status;
  logic [31:0]       status_w;

  // Limit writes are blocked while the reset pulse is active.
  always_comb begin
    wr_hit  = wr_en && (addr == A_LIMIT) && !pulse_act;
    wr_arm  = wr_hit && (wdata != '0);
    wr_stop = wr_hit && (wdata == '0);
  end

  // A write wins over expiry; expiry clears the stored limit.
  always_comb begin
    limit_en = 1'b0;
    limit_d  = limit_q;
    if (wr_hit) begin
      limit_en = 1'b1;
      limit_d  = wdata;
    end else if (expire) begin
      limit_en = 1'b1;
      limit_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
    end else if (limit_en) begin
      limit_q <= limit_d;
    end
  end

  // Read mux: a combinational path, qualified by rd_en.
  always_comb begin
    status.pulse = pulse_act;
    status.armed = armed;
    status_w     = status_word(status);
    rdata        = '0;
    if (rd_en) begin
      if (addr == A_LIMIT) begin
        rdata = limit_q;
      end else if (addr == A_COUNT) begin
        rdata = count;
      end else if (addr == A_STATUS) begin
        rdata = DATA_W'(status_w);
      end
    end
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              wr_arm,
  input  logic              wr_stop,
  input  logic [DATA_W-1:0] limit,
  output logic              armed_q,
  output logic [DATA_W-1:0] count_q,
  output logic              expire
);

  logic              at_limit;
  logic              armed_d;
  logic              armed_en;
  logic [DATA_W-1:0] count_d;
  logic              count_en;

  always_comb begin
    at_limit = (count_q == limit);
    expire   = armed_q && at_limit && !wr_hit;
  end

  // Next state for the armed flag.
  always_comb begin
    armed_en = 1'b0;
    armed_d  = armed_q;
    if (wr_arm) begin
      armed_en = 1'b1;
      armed_d  = 1'b1;
    end else if (wr_stop || expire) begin
      armed_en = 1'b1;
      armed_d  = 1'b0;
    end
  end

  // Next state for the counter: clear on arm, step while below the limit.
  always_comb begin
    count_en = 1'b0;
    count_d  = count_q;
    if (wr_arm) begin
      count_en = 1'b1;
      count_d  = '0;
    end else if (armed_q && !at_limit && !wr_stop) begin
      count_en = 1'b1;
      count_d  = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (armed_en) begin
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen
  import wdog_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  output logic                pulse_act_q,
  output logic [RST_OUTS-1:0] rst_out_n
);

  localparam int PCNT_W = (PULSE_LEN < 2) ? 1 : $clog2(PULSE_LEN + 1);
  localparam logic [PCNT_W-1:0] PCNT_LOAD = PCNT_W'(PULSE_LEN - 1);

  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] pcnt_d;
  logic              act_d;
  logic              state_en;

  // Next state of the pulse timer.
  always_comb begin
    state_en = 1'b0;
    act_d    = pulse_act_q;
    pcnt_d   = pcnt_q;
    if (fire) begin
      state_en = 1'b1;
      act_d    = 1'b1;
      pcnt_d   = PCNT_LOAD;
    end else if (pulse_act_q) begin
      state_en = 1'b1;
      if (pcnt_q == '0) begin
        act_d = 1'b0;
      end else begin
        pcnt_d = pcnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_act_q <= 1'b0;
      pcnt_q      <= '0;
    end else if (state_en) begin
      pulse_act_q <= act_d;
      pcnt_q      <= pcnt_d;
    end
  end

  // One registered driver per reset output, so each has its own fan-out tree.
  for (genvar g = 0; g < RST_OUTS; g++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rst_out_n[g] <= 1'b1;
      end else if (state_en) begin
        rst_out_n[g] <= ~act_d;
      end
    end
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int PULSE_LEN   = 16,
  parameter int LIMIT_ADDR  = 0,
  parameter int COUNT_ADDR  = 4,
  parameter int STATUS_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              armed,
  output logic              periph_rst_n,
  output logic              sys_rst_n
);

  logic                rst_sync_n;
  logic                wr_hit;
  logic                wr_arm;
  logic                wr_stop;
  logic                expire;
  logic                pulse_act;
  logic                armed_q;
  logic [DATA_W-1:0]   limit_q;
  logic [DATA_W-1:0]   count_q;
  logic [RST_OUTS-1:0] rst_out_n;

  wdog_rst_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdog_regif #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .LIMIT_ADDR  (LIMIT_ADDR),
    .COUNT_ADDR  (COUNT_ADDR),
    .STATUS_ADDR (STATUS_ADDR)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .expire    (expire),
    .pulse_act (pulse_act),
    .armed     (armed_q),
    .count     (count_q),
    .wr_hit    (wr_hit),
    .wr_arm    (wr_arm),
    .wr_stop   (wr_stop),
    .limit_q   (limit_q),
    .rdata     (rdata)
  );

  wdog_counter #(
    .DATA_W (DATA_W)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_hit  (wr_hit),
    .wr_arm  (wr_arm),
    .wr_stop (wr_stop),
    .limit   (limit_q),
    .armed_q (armed_q),
    .count_q (count_q),
    .expire  (expire)
  );

  wdog_rstgen #(
    .PULSE_LEN (PULSE_LEN)
  ) u_rstgen (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .fire        (expire),
    .pulse_act_q (pulse_act),
    .rst_out_n   (rst_out_n)
  );

  assign armed        = armed_q;
  assign periph_rst_n = rst_out_n[OUT_PERIPH];
  assign sys_rst_n    = rst_out_n[OUT_SYSTEM];

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int PULSE_LEN  = 16,
  parameter int LIMIT_ADDR = 0
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              armed,
  input logic              periph_rst_n,
  input logic              sys_rst_n,
  input logic [DATA_W-1:0] limit_q,
  input logic [DATA_W-1:0] count_q
);

  logic        lim_wr;
  logic [31:0] low_run;

  assign lim_wr = wr_en && (addr == ADDR_W'(LIMIT_ADDR));

  // Length of the current low stretch of the reset outputs.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      low_run <= '0;
    end else begin
      low_run <= periph_rst_n ? 32'd0 : low_run + 32'd1;
    end
  end

  assert_outs_match_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    periph_rst_n == sys_rst_n);

  assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(periph_rst_n) |-> low_run == 32'(PULSE_LEN));

  assert_fire_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && count_q == limit_q && !lim_wr) |=> (!periph_rst_n && !armed));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && count_q != limit_q && !lim_wr) |=> count_q == $past(count_q) + 1'b1);

  assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lim_wr && wdata != '0 && periph_rst_n) |=>
      (armed && count_q == '0 && limit_q == $past(wdata)));

  assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lim_wr && wdata == '0 && periph_rst_n) |=> (!armed && $stable(count_q)));

  assert_priority_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && count_q == limit_q && lim_wr) |=> periph_rst_n);

  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!periph_rst_n && wr_en) |=> !armed);

endmodule

bind wdog_timer wdog_timer_chk #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .PULSE_LEN  (PULSE_LEN),
  .LIMIT_ADDR (LIMIT_ADDR)
) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .wr_en        (wr_en),
  .addr         (addr),
  .wdata        (wdata),
  .armed        (armed),
  .periph_rst_n (periph_rst_n),
  .sys_rst_n    (sys_rst_n),
  .limit_q      (limit_q),
  .count_q      (count_q)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;

  localparam int PULSE = 16;
  localparam logic [3:0] A_LIM = 4'h0;
  localparam logic [3:0] A_CNT = 4'h4;
  localparam logic [3:0] A_STS = 4'h8;
  localparam logic [3:0] A_BAD = 4'hC;

  // Vector fields: [48:17] limit, [16:1] cycle of a zero write (0 = none), [0] reset expected.
  localparam int NVEC = 8;
  localparam logic [48:0] VECS [NVEC] = '{
    {32'd1,  16'd0,  1'b1},
    {32'd2,  16'd0,  1'b1},
    {32'd5,  16'd0,  1'b1},
    {32'd37, 16'd0,  1'b1},
    {32'd10, 16'd4,  1'b0},
    {32'd10, 16'd10, 1'b0},
    {32'd12, 16'd11, 1'b0},
    {32'd3,  16'd3,  1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        armed;
  logic        periph_rst_n;
  logic        sys_rst_n;

  int checks;
  int errors;
  bit done;

  wdog_timer dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .armed        (armed),
    .periph_rst_n (periph_rst_n),
    .sys_rst_n    (sys_rst_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Called at a falling edge; returns at the falling edge after the write edge.
  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1;
    addr  = a;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    wdata = '0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1;
    addr  = a;
    #0.5;
    d     = rdata;
    rd_en = 1'b0;
  endtask

  // Waits up to maxc cycles; reports the first low cycle and the number of low cycles.
  task automatic wait_fire(input int maxc, output int at, output int lows);
    at   = 0;
    lows = 0;
    for (int k = 1; k <= maxc; k++) begin
      tick();
      if (!periph_rst_n) begin
        if (at == 0) at = k;
        lows++;
      end
      if (periph_rst_n !== sys_rst_n) check("R4 outputs equal", {31'd0, sys_rst_n}, {31'd0, periph_rst_n});
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    int at;
    int lows;
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    wr_en  = 1'b0;
    rd_en  = 1'b0;
    addr   = '0;
    wdata  = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1: reset state
    check("R1 armed", {31'd0, armed}, 32'd0);
    check("R1 periph_rst_n", {31'd0, periph_rst_n}, 32'd1);
    check("R1 sys_rst_n", {31'd0, sys_rst_n}, 32'd1);
    reg_rd(A_LIM, rv); check("R1 limit", rv, 32'd0);
    reg_rd(A_CNT, rv); check("R1 count", rv, 32'd0);

    // Vector table: R2, R3, R4, R5, R7
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] lim;
      int stop_at;
      bit expect_fire;
      int fire_at;
      int low_cnt;
      lim         = VECS[v][48:17];
      stop_at     = int'(VECS[v][16:1]);
      expect_fire = VECS[v][0];
      fire_at     = 0;
      low_cnt     = 0;
      reg_wr(A_LIM, lim);
      for (int k = 0; k < int'(lim) + PULSE + 6; k++) begin
        if (k == 0) begin
          reg_rd(A_LIM, rv); check("R2 limit stored", rv, lim);
          reg_rd(A_CNT, rv); check("R2 count cleared", rv, 32'd0);
          check("R2 armed", {31'd0, armed}, 32'd1);
        end
        if (k == 2 && lim >= 2) begin
          reg_rd(A_CNT, rv); check("R2 count steps", rv, 32'd2);
        end
        if (stop_at != 0 && k == stop_at) begin
          wr_en = 1'b1; addr = A_LIM; wdata = '0;
        end else begin
          wr_en = 1'b0;
        end
        tick();
        if (!periph_rst_n) begin
          if (fire_at == 0) fire_at = k + 1;
          low_cnt++;
        end
        if (periph_rst_n !== sys_rst_n) check("R4 outputs equal", {31'd0, sys_rst_n}, {31'd0, periph_rst_n});
      end
      wr_en = 1'b0;
      check("R3/R5 armed after", {31'd0, armed}, 32'd0);
      reg_rd(A_LIM, rv); check("R4/R5 limit cleared", rv, 32'd0);
      if (expect_fire) begin
        check("R3 fire cycle", fire_at, int'(lim) + 1);
        check("R4 pulse length", low_cnt, PULSE);
        check("R4 released", {31'd0, periph_rst_n}, 32'd1);
      end else begin
        check("R5/R7 no reset", low_cnt, 0);
        reg_rd(A_CNT, rv); check("R5 count frozen", rv, 32'(stop_at));
      end
    end

    // R6: nonzero rewrite restarts against the new limit
    reg_wr(A_LIM, 32'd20);
    repeat (10) tick();
    reg_wr(A_LIM, 32'd5);
    reg_rd(A_CNT, rv); check("R6 restart count", rv, 32'd0);
    reg_rd(A_LIM, rv); check("R6 new limit", rv, 32'd5);
    wait_fire(30, at, lows);
    check("R6 fire cycle", at, 6);

    // R7: nonzero write on the terminal cycle re-arms, no reset
    reg_wr(A_LIM, 32'd4);
    repeat (4) tick();
    reg_wr(A_LIM, 32'd50);
    wait_fire(20, at, lows);
    check("R7 nonzero priority no reset", lows, 0);
    check("R7 still armed", {31'd0, armed}, 32'd1);
    reg_rd(A_STS, rv); check("R9 status armed", rv, 32'd1);
    reg_wr(A_LIM, 32'd0);

    // R8: writes ignored during the reset pulse
    reg_wr(A_LIM, 32'd3);
    repeat (4) tick();
    check("R8 pulse started", {31'd0, periph_rst_n}, 32'd0);
    reg_rd(A_STS, rv); check("R9 status pulse", rv, 32'd2);
    reg_wr(A_LIM, 32'd100);
    check("R8 armed stays low", {31'd0, armed}, 32'd0);
    repeat (PULSE) tick();
    check("R8 pulse ended", {31'd0, periph_rst_n}, 32'd1);
    reg_rd(A_LIM, rv); check("R8 limit not taken", rv, 32'd0);
    wait_fire(120, at, lows);
    check("R8 no second reset", lows, 0);

    // R9: read map and writes to other addresses
    reg_wr(A_CNT, 32'd7);
    check("R9 count write ignored armed", {31'd0, armed}, 32'd0);
    reg_rd(A_LIM, rv); check("R9 count write ignored limit", rv, 32'd0);
    reg_wr(A_LIM, 32'd9);
    reg_rd(A_BAD, rv); check("R9 unmapped address", rv, 32'd0);
    addr = A_LIM; rd_en = 1'b0; #0.5;
    check("R9 rd_en low", rdata, 32'd0);
    reg_wr(A_LIM, 32'd0);

    // R2: full-width limit keeps counting
    reg_wr(A_LIM, 32'hFFFF_FFFF);
    repeat (3) tick();
    reg_rd(A_CNT, rv); check("R2 count at max limit", rv, 32'd3);
    reg_wr(A_LIM, 32'd0);
    reg_rd(A_CNT, rv); check("R5 frozen after zero", rv, 32'd3);
    check("R5 disarmed", {31'd0, armed}, 32'd0);

    // R10: asynchronous reset during a pulse
    reg_wr(A_LIM, 32'd2);
    repeat (3) tick();
    check("R10 pulse active", {31'd0, periph_rst_n}, 32'd0);
    #1 rst_n = 1'b0;
    #0.5;
    check("R10 periph released", {31'd0, periph_rst_n}, 32'd1);
    check("R10 sys released", {31'd0, sys_rst_n}, 32'd1);
    check("R10 disarmed", {31'd0, armed}, 32'd0);
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
    reg_rd(A_LIM, rv); check("R10/R1 limit after reset", rv, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule